// File: doc/BRIEF.md
# Multi-channel PWM generator with staged, glitch-free reload

This block produces a set of independent pulse-width-modulated outputs from one clock. Each channel runs from a prescaler and a period counter. The channel output is active while the period count is below that channel's duty-high count. Software programs the block through a plain write/read register bus. New prescale, period and duty values first go into shadow storage. They reach the running counters only after a qualified trigger handshake, and only at the end of a whole period. A waveform therefore never shows a shortened or stretched cycle during reconfiguration.

One control word holds four bits per channel: trigger, smooth, polarity and output type. While the smooth bit is set and the trigger bit is clear, software may rewrite the shadows and the old waveform keeps running unchanged. A trigger counts only if it stays high for a programmable number of clock cycles, and only if it was low for the same number of cycles beforehand. The default of 40 cycles is 400 ns at a 100 MHz clock. A channel whose smooth and trigger bits are both clear forces its output high. The block does not gate clocks, drive pads, raise interrupts or compute counts.

Top module: `pwmr_top`

## Requirements
- R1: After synchronous reset every control bit, prescale, period and duty register reads 0. Every channel output is high and every output enable is low.
- R2: Address 0 is the control word, with bit 4c = trigger, 4c+1 = smooth, 4c+2 = polarity and 4c+3 = output type for channel c. Address 1 holds the prescale of channel c in bits [c*PS_W +: PS_W]. Address 2+2c is the period count of channel c and address 3+2c its duty count. A read returns the value last written.
- R3: While a channel's smooth bit is 1 and its trigger bit is 0, writes to its prescale, period or duty registers leave its output waveform unchanged.
- R4: A trigger bit held high for HOLD_CYC consecutive cycles captures the channel's shadow values for loading. A high pulse shorter than HOLD_CYC captures nothing.
- R5: A rising trigger qualifies only after the trigger bit has been low for HOLD_CYC consecutive cycles, and this also applies after reset. A rise that comes after a shorter low gap is ignored until the bit falls again.
- R6: With normal polarity, period count P > 0, duty count 0 < D < P and prescale S, the output is high for D*(S+1) cycles and low for (P-D)*(S+1) cycles of every period.
- R7: Captured values replace the running ones only at the end of a complete period. Every observed period matches either the old or the new settings, and a channel whose running period count is 0 loads at once.
- R8: When both the smooth and the trigger bit of a channel are 0, its output is constantly high.
- R9: Polarity bit 1 gives normal output and 0 gives inverted output. The bit is not shadowed and acts at once.
- R10: A running duty count greater than or equal to a nonzero running period count gives a constantly active output.
- R11: A running period count of 0 is the disabled state. The output then rests at the inactive level: low for normal polarity, high for inverted.
- R12: Output type 1 selects push-pull drive, where the output enable is always 1. Type 0 selects open-drain drive, where the output enable is 1 exactly when the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (3 bits by default) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| pwm_o | output | NCH | Channel output levels |
| pwm_oe | output | NCH | Channel output enables |

## Verification
The bench steps through a table of settings. Before each trigger it rewrites the shadows and confirms the old high and low times persist. It then measures consecutive periods across the trigger and requires an old run followed by a new run. A design that loaded mid-period would show a period matching neither. A trigger pulse that is too short and a re-raise after too short a low gap must both leave the waveform untouched; a design without qualification would switch early. The bench also covers the forced-high state with both control bits low, full duty, the disabled rest level under each polarity, and the open-drain enable, where a wrong design would drive a high level or drop the low.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;

    // Per-channel control nibble; field order fixes the bit positions in the control word.
    typedef struct packed {
        logic ptype;   // 1: push-pull, 0: open-drain
        logic pol;     // 1: normal, 0: inverted
        logic smooth;  // keep old waveform while staging
        logic trig;    // load request
    } pwmr_ctrl_t;

    localparam int CTRL_STRIDE    = $bits(pwmr_ctrl_t);
    localparam int ADDR_CTRL      = 0;
    localparam int ADDR_PRESC     = 1;
    localparam int ADDR_CHAN_BASE = 2;

    typedef enum logic [1:0] {
        ARM_WAIT_LOW,
        ARM_READY,
        ARM_HOLDING,
        ARM_SPENT
    } pwmr_arm_e;

    function automatic int chan_addr(input int ch, input bit is_duty);
        return ADDR_CHAN_BASE + 2 * ch + (is_duty ? 1 : 0);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic out_level(input logic raw, input pwmr_ctrl_t cb);
        if (!cb.smooth && !cb.trig) begin
            return 1'b1;
        end
        return cb.pol ? raw : !raw;
    endfunction

endpackage

// File: rtl/pwmr_regs.sv
module pwmr_regs
    import pwmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 8,
    parameter int PS_W   = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output pwmr_ctrl_t [NCH-1:0]        ctrl_o,
    output logic [NCH-1:0][PS_W-1:0]    ps_o,
    output logic [NCH-1:0][CNT_W-1:0]   per_o,
    output logic [NCH-1:0][CNT_W-1:0]   duty_o
);

    localparam int USED_W = max3(NCH * CTRL_STRIDE, NCH * PS_W, CNT_W);

    pwmr_ctrl_t [NCH-1:0]      ctrl_q;
    logic [NCH-1:0][PS_W-1:0]  ps_q;
    logic [NCH-1:0][CNT_W-1:0] per_q;
    logic [NCH-1:0][CNT_W-1:0] duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ps_q   <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_W'(ADDR_CTRL)) begin
                    ctrl_q[c] <= wdata[c*CTRL_STRIDE +: CTRL_STRIDE];
                end
                if (addr == ADDR_W'(ADDR_PRESC)) begin
                    ps_q[c] <= wdata[c*PS_W +: PS_W];
                end
                if (addr == ADDR_W'(chan_addr(c, 1'b0))) begin
                    per_q[c] <= wdata[CNT_W-1:0];
                end
                if (addr == ADDR_W'(chan_addr(c, 1'b1))) begin
                    duty_q[c] <= wdata[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == ADDR_W'(ADDR_CTRL)) begin
                rdata[c*CTRL_STRIDE +: CTRL_STRIDE] = ctrl_q[c];
            end
            if (addr == ADDR_W'(ADDR_PRESC)) begin
                rdata[c*PS_W +: PS_W] = ps_q[c];
            end
            if (addr == ADDR_W'(chan_addr(c, 1'b0))) begin
                rdata[CNT_W-1:0] = per_q[c];
            end
            if (addr == ADDR_W'(chan_addr(c, 1'b1))) begin
                rdata[CNT_W-1:0] = duty_q[c];
            end
        end
    end

    generate
        if (USED_W < DATA_W) begin : g_spare
            logic unused_hi_bits;
            assign unused_hi_bits = ^wdata[DATA_W-1:USED_W];
        end
    endgenerate

    assign ctrl_o = ctrl_q;
    assign ps_o   = ps_q;
    assign per_o  = per_q;
    assign duty_o = duty_q;

endmodule

// File: rtl/pwmr_arm.sv
module pwmr_arm
    import pwmr_pkg::*;
#(
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic take_o
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

    pwmr_arm_e     st_q;
    logic [HW-1:0] cnt_q;

    // cnt_q: qualifying cycles already seen before the current one.
    assign take_o = (st_q == ARM_HOLDING) && trig && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ARM_WAIT_LOW;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ARM_WAIT_LOW: begin
                    if (trig) begin
                        cnt_q <= '0;
                    end else if (cnt_q == LAST) begin
                        st_q <= ARM_READY;
                    end else begin
                        cnt_q <= cnt_q + HW'(1);
                    end
                end
                ARM_READY: begin
                    if (trig) begin
                        st_q  <= ARM_HOLDING;
                        cnt_q <= HW'(1);
                    end
                end
                ARM_HOLDING: begin
                    if (!trig) begin
                        st_q  <= ARM_WAIT_LOW;
                        cnt_q <= HW'(1);
                    end else if (cnt_q == LAST) begin
                        st_q <= ARM_SPENT;
                    end else begin
                        cnt_q <= cnt_q + HW'(1);
                    end
                end
                default: begin
                    if (!trig) begin
                        st_q  <= ARM_WAIT_LOW;
                        cnt_q <= HW'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pwmr_chan.sv
module pwmr_chan #(
    parameter int CNT_W = 8,
    parameter int PS_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [PS_W-1:0]  sh_ps,
    input  logic [CNT_W-1:0] sh_per,
    input  logic [CNT_W-1:0] sh_duty,
    output logic             raw_o,
    output logic [CNT_W-1:0] act_per_o,
    output logic [CNT_W-1:0] act_duty_o
);

    logic [PS_W-1:0]  act_ps, pend_ps, pre_q;
    logic [CNT_W-1:0] act_per, act_duty, pend_per, pend_duty, cnt_q;
    logic             pend_vld;
    logic             idle, tick, last, boundary;

    assign idle     = (act_per == '0);
    assign tick     = (pre_q == act_ps);
    assign last     = (cnt_q == act_per - CNT_W'(1));
    assign boundary = idle || (tick && last);
    assign raw_o    = !idle && (cnt_q < act_duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_ps    <= '0;
            act_per   <= '0;
            act_duty  <= '0;
            pend_ps   <= '0;
            pend_per  <= '0;
            pend_duty <= '0;
            pend_vld  <= 1'b0;
            pre_q     <= '0;
            cnt_q     <= '0;
        end else begin
            if (pend_vld && boundary) begin
                act_ps   <= pend_ps;
                act_per  <= pend_per;
                act_duty <= pend_duty;
                pend_vld <= 1'b0;
                pre_q    <= '0;
                cnt_q    <= '0;
            end else if (!idle) begin
                if (tick) begin
                    pre_q <= '0;
                    cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
                end else begin
                    pre_q <= pre_q + PS_W'(1);
                end
            end
            if (take) begin
                pend_ps   <= sh_ps;
                pend_per  <= sh_per;
                pend_duty <= sh_duty;
                pend_vld  <= 1'b1;
            end
        end
    end

    assign act_per_o  = act_per;
    assign act_duty_o = act_duty;

endmodule

// File: rtl/pwmr_drive.sv
module pwmr_drive
    import pwmr_pkg::*;
(
    input  logic       raw,
    input  pwmr_ctrl_t cb,
    output logic       out_o,
    output logic       oe_o
);

    always_comb begin
        out_o = out_level(raw, cb);
        oe_o  = cb.ptype ? 1'b1 : !out_o;
    end

endmodule

// File: rtl/pwmr_top.sv
module pwmr_top
    import pwmr_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int CNT_W    = 8,
    parameter int PS_W     = 4,
    parameter int DATA_W   = 32,
    parameter int HOLD_CYC = 40,
    parameter int ADDR_W   = $clog2(ADDR_CHAN_BASE + 2 * NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_o,
    output logic [NCH-1:0]    pwm_oe
);

    pwmr_ctrl_t [NCH-1:0]      ctrl;
    logic [NCH-1:0][PS_W-1:0]  ps;
    logic [NCH-1:0][CNT_W-1:0] per, duty, act_per_v, act_duty_v;
    logic [NCH-1:0]            take_v, raw_v, trig_v, smooth_v, pol_v, ptype_v;

    pwmr_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ctrl_o(ctrl), .ps_o(ps), .per_o(per), .duty_o(duty)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            assign trig_v[g]   = ctrl[g].trig;
            assign smooth_v[g] = ctrl[g].smooth;
            assign pol_v[g]    = ctrl[g].pol;
            assign ptype_v[g]  = ctrl[g].ptype;

            pwmr_arm #(.HOLD_CYC(HOLD_CYC)) arm_i (
                .clk(clk), .rst(rst), .trig(trig_v[g]), .take_o(take_v[g])
            );

            pwmr_chan #(.CNT_W(CNT_W), .PS_W(PS_W)) chan_i (
                .clk(clk), .rst(rst), .take(take_v[g]),
                .sh_ps(ps[g]), .sh_per(per[g]), .sh_duty(duty[g]),
                .raw_o(raw_v[g]), .act_per_o(act_per_v[g]), .act_duty_o(act_duty_v[g])
            );

            pwmr_drive drive_i (
                .raw(raw_v[g]), .cb(ctrl[g]), .out_o(pwm_o[g]), .oe_o(pwm_oe[g])
            );
        end
    endgenerate

endmodule

// File: rtl/pwmr_chk.sv
module pwmr_chk #(
    parameter int NCH   = 2,
    parameter int CNT_W = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NCH-1:0]            trig,
    input logic [NCH-1:0]            smooth,
    input logic [NCH-1:0]            pol,
    input logic [NCH-1:0]            ptype,
    input logic [NCH-1:0]            take,
    input logic [NCH-1:0][CNT_W-1:0] act_per,
    input logic [NCH-1:0][CNT_W-1:0] act_duty,
    input logic [NCH-1:0]            pwm_o,
    input logic [NCH-1:0]            pwm_oe
);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            a_r8_both_low_high: assert property (@(posedge clk) disable iff (rst)
                (!smooth[c] && !trig[c]) |-> pwm_o[c]);

            a_r12_push_pull: assert property (@(posedge clk) disable iff (rst)
                ptype[c] |-> pwm_oe[c]);

            a_r12_open_drain: assert property (@(posedge clk) disable iff (rst)
                !ptype[c] |-> (pwm_oe[c] != pwm_o[c]));

            a_r4_take_after_hold: assert property (@(posedge clk) disable iff (rst)
                take[c] |-> (trig[c] && $past(trig[c])));

            a_r11_disabled_rest: assert property (@(posedge clk) disable iff (rst)
                ((act_per[c] == '0) && (smooth[c] || trig[c])) |-> (pwm_o[c] == !pol[c]));

            a_r10_full_duty: assert property (@(posedge clk) disable iff (rst)
                ((act_per[c] != '0) && (act_duty[c] >= act_per[c]) && (smooth[c] || trig[c]))
                    |-> (pwm_o[c] == pol[c]));
        end
    endgenerate

endmodule

bind pwmr_top pwmr_chk #(.NCH(NCH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .trig(trig_v), .smooth(smooth_v), .pol(pol_v),
    .ptype(ptype_v), .take(take_v), .act_per(act_per_v), .act_duty(act_duty_v),
    .pwm_o(pwm_o), .pwm_oe(pwm_oe)
);

// File: tb/pwmr_top_tb_top.sv
module pwmr_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int CNT_W      = 8;
    localparam int PS_W       = 4;
    localparam int DATA_W     = 32;
    localparam int HOLD       = 40;
    localparam int ADDR_W     = $clog2(2 + 2 * NCH);
    localparam int NVEC       = 5;
    localparam int NMEAS      = 10;
    // prescale, period, duty, expected high cycles, expected low cycles
    localparam int VEC [NVEC][5] = '{
        '{0, 10, 3,  3,  7},
        '{1,  8, 2,  4, 12},
        '{2,  5, 4, 12,  3},
        '{0,  6, 1,  1,  5},
        '{3,  4, 2,  8,  8}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NCH-1:0]    pwm_o, pwm_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [DATA_W-1:0] ctrl_sh = '0;
    logic [DATA_W-1:0] ps_sh   = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwmr_top #(
        .NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W), .DATA_W(DATA_W), .HOLD_CYC(HOLD)
    ) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = ADDR_W'(a);
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = ADDR_W'(a);
        #1;
        d = rdata;
    endtask

    task automatic set_bit(input int ch, input int pos, input bit v);
        ctrl_sh[4*ch + pos] = v;
        bus_wr(0, ctrl_sh);
    endtask

    task automatic load_shadow(input int ch, input int ps, input int per, input int duty);
        ps_sh[ch*PS_W +: PS_W] = PS_W'(ps);
        bus_wr(1, ps_sh);
        bus_wr(2 + 2*ch, DATA_W'(per));
        bus_wr(3 + 2*ch, DATA_W'(duty));
    endtask

    task automatic pulse_trig(input int ch, input int n);
        set_bit(ch, 0, 1'b1);
        repeat (n) @(negedge clk);
        set_bit(ch, 0, 1'b0);
    endtask

    task automatic apply(input int ch, input int ps, input int per, input int duty);
        load_shadow(ch, ps, per, duty);
        pulse_trig(ch, HOLD + 2);
        repeat (HOLD + 40) @(negedge clk);
    endtask

    task automatic measure(input int ch, output int hi, output int lo);
        int g;
        hi = 0;
        lo = 0;
        g = 0;
        while (pwm_o[ch] && g < 2000) begin @(negedge clk); g++; end
        while (!pwm_o[ch] && g < 2000) begin @(negedge clk); g++; end
        while (pwm_o[ch] && g < 2000) begin @(negedge clk); g++; hi++; end
        while (!pwm_o[ch] && g < 2000) begin @(negedge clk); g++; lo++; end
        if (g >= 2000) begin
            hi = -1;
            lo = -1;
        end
    endtask

    task automatic expect_wave(input int ch, input int eh, input int el, input string req);
        int h, l;
        measure(ch, h, l);
        check(h == eh, req, h, eh);
        check(l == el, req, l, el);
    endtask

    task automatic expect_level(input int ch, input bit v, input int n, input string req);
        int miss = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o[ch] != v) miss++;
        end
        check(miss == 0, req, miss, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] rd;
        int ph, pl;
        int mh [NMEAS];
        int ml [NMEAS];

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(pwm_o == 2'b11, "R1 out", int'(pwm_o), 3);
        check(pwm_oe == 2'b00, "R1 oe", int'(pwm_oe), 0);
        bus_rd(0, rd);
        check(rd == 0, "R1 ctrl", int'(rd), 0);
        bus_rd(2, rd);
        check(rd == 0, "R1 period", int'(rd), 0);

        // R2: register map readback
        bus_wr(4, 32'h5A);
        bus_rd(4, rd);
        check(rd == 32'h5A, "R2 period ch1", int'(rd), 'h5A);
        ps_sh = 32'h30;
        bus_wr(1, ps_sh);
        bus_rd(1, rd);
        check(rd == 32'h30, "R2 prescale", int'(rd), 'h30);
        ps_sh = '0;
        bus_wr(1, ps_sh);
        bus_wr(4, 32'h0);

        // R11: channel 0 enabled, normal polarity, nothing loaded
        ctrl_sh = 32'h6;
        bus_wr(0, ctrl_sh);
        bus_rd(0, rd);
        check(rd == 32'h6, "R2 ctrl", int'(rd), 6);
        expect_level(0, 1'b0, 20, "R11 disabled normal");

        // R6/R7: first load from disabled state
        apply(0, 0, 12, 6);
        expect_wave(0, 6, 6, "R6 initial");
        ph = 6;
        pl = 6;

        for (int v = 0; v < NVEC; v++) begin
            int nh, nl, first_new, bad_seq;
            nh = VEC[v][3];
            nl = VEC[v][4];
            // R3: staging keeps old waveform
            load_shadow(0, VEC[v][0], VEC[v][1], VEC[v][2]);
            expect_wave(0, ph, pl, "R3 staging");
            expect_wave(0, ph, pl, "R3 staging");
            fork
                begin
                    pulse_trig(0, HOLD + 2);
                end
                begin
                    for (int m = 0; m < NMEAS; m++) measure(0, mh[m], ml[m]);
                end
            join
            first_new = -1;
            bad_seq = 0;
            for (int m = 0; m < NMEAS; m++) begin
                bit is_old, is_new;
                is_old = (mh[m] == ph) && (ml[m] == pl);
                is_new = (mh[m] == nh) && (ml[m] == nl);
                if (is_new && first_new < 0) first_new = m;
                if (!is_old && !is_new) bad_seq++;
                if (first_new >= 0 && !is_new) bad_seq++;
            end
            check(mh[0] == ph && ml[0] == pl, "R4 old during hold", mh[0], ph);
            check(bad_seq == 0, "R7 clean switch", bad_seq, 0);
            check(mh[NMEAS-1] == nh, "R6 new high", mh[NMEAS-1], nh);
            check(ml[NMEAS-1] == nl, "R6 new low", ml[NMEAS-1], nl);
            repeat (HOLD + 3) @(negedge clk);
            ph = nh;
            pl = nl;
        end

        // R4: short trigger pulse ignored
        load_shadow(0, 0, 10, 5);
        pulse_trig(0, HOLD - 5);
        repeat (HOLD + 40) @(negedge clk);
        expect_wave(0, 8, 8, "R4 short pulse");

        // R5: re-raise after short low gap ignored
        set_bit(0, 0, 1'b1);
        repeat (HOLD + 2) @(negedge clk);
        load_shadow(0, 1, 6, 3);
        set_bit(0, 0, 1'b0);
        repeat (2) @(negedge clk);
        set_bit(0, 0, 1'b1);
        repeat (HOLD + 5) @(negedge clk);
        set_bit(0, 0, 1'b0);
        repeat (HOLD + 40) @(negedge clk);
        expect_wave(0, 5, 5, "R5 short re-arm");
        pulse_trig(0, HOLD + 2);
        repeat (HOLD + 40) @(negedge clk);
        expect_wave(0, 6, 6, "R5 proper re-arm");

        // R8: both bits low forces high, counter keeps running
        set_bit(0, 1, 1'b0);
        expect_level(0, 1'b1, 60, "R8 both low");
        set_bit(0, 1, 1'b1);
        expect_wave(0, 6, 6, "R8 resume");

        // R10: full duty
        apply(0, 0, 5, 9);
        expect_level(0, 1'b1, 40, "R10 duty above period");
        apply(0, 0, 5, 5);
        expect_level(0, 1'b1, 40, "R10 duty equals period");

        // R9: inverted polarity
        apply(0, 0, 10, 3);
        set_bit(0, 2, 1'b0);
        expect_wave(0, 7, 3, "R9 inverted");

        // R11: disabled rest level for both polarities
        apply(0, 0, 0, 0);
        expect_level(0, 1'b1, 40, "R11 disabled inverted");
        set_bit(0, 2, 1'b1);
        expect_level(0, 1'b0, 40, "R11 disabled normal");

        // R12: output type on channel 1 (disabled, normal)
        set_bit(1, 1, 1'b1);
        set_bit(1, 2, 1'b1);
        @(negedge clk);
        check(pwm_o[1] == 1'b0, "R12 ch1 low", int'(pwm_o[1]), 0);
        check(pwm_oe[1] == 1'b1, "R12 open-drain drives low", int'(pwm_oe[1]), 1);
        set_bit(1, 1, 1'b0);
        @(negedge clk);
        check(pwm_oe[1] == 1'b0, "R12 open-drain releases high", int'(pwm_oe[1]), 0);
        set_bit(1, 3, 1'b1);
        @(negedge clk);
        check(pwm_o[1] == 1'b1 && pwm_oe[1] == 1'b1, "R12 push-pull high",
              int'(pwm_oe[1]), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule